// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segmented virtual address into a physical address. A request carries a segment number, an offset inside that segment and an access kind (instruction fetch, load or store). The segment number picks one entry of a small on-chip table. Each entry holds a base address, a limit, a permission mask and a valid flag. The offset is first checked against the limit. If it passes, it is added to the base to form the physical address.

Every access is screened three ways: the entry must be valid, the offset must lie inside the segment, and the access kind must be allowed by the entry's mask. A code segment is usually loaded with fetch and load allowed and store refused. Data and stack segments also allow store. A failed screen returns a fault flag, a two-bit cause and no address. Software or a loader fills the table through a dedicated write port. Each response comes back on a registered output exactly one cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: The segment field indexes the table directly. On an access with no fault, rsp_paddr equals the entry base plus the zero-extended offset, truncated to PA_W bits.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high. Back-to-back requests give back-to-back responses.
- R3: An offset greater than or equal to the entry limit gives cause 2'b10. An offset equal to limit-1 is translated normally.
- R4: Permission mask bit 0 allows fetch (access code 2'b00), bit 1 allows load (2'b01) and bit 2 allows store (2'b10). An access whose bit is clear gives cause 2'b11. Access code 2'b11 is always refused with cause 2'b11.
- R5: An access to an entry whose valid flag is clear gives cause 2'b01. Reset clears every valid flag.
- R6: When several faults apply, the reported cause follows the order invalid (2'b01), then limit (2'b10), then permission (2'b11).
- R7: rsp_fault is high exactly when rsp_cause is not 2'b00, and rsp_paddr is zero on every faulting response.
- R8: A table write and a lookup of the same entry in the same cycle see the old entry contents, including its valid flag. The new contents apply from the next cycle.
- R9: In reset, and in any cycle that follows a cycle without a request, rsp_valid, rsp_fault, rsp_cause and rsp_paddr are all zero.
- R10: A limit of zero refuses every offset. A limit of 2**OFF_W admits every offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 reserved |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_paddr | output | PA_W | Physical address, zero on fault |
| rsp_fault | output | 1 | Protection fault |
| rsp_cause | output | 2 | 00 none, 01 invalid, 10 limit, 11 permission |
| wr_en | input | 1 | Write one table entry |
| wr_seg | input | SEG_W | Entry to write |
| wr_valid | input | 1 | Valid flag written to the entry |
| wr_base | input | PA_W | Base address written to the entry |
| wr_limit | input | OFF_W+1 | Limit written to the entry |
| wr_perm | input | 3 | Permission mask written to the entry |

## Verification
The bench builds the translator with SEG_W=2, OFF_W=8 and PA_W=10, so all four entries can be given distinct roles: a code segment, a full-size data segment, a zero-limit segment, and one left invalid and later reused. With a 10-bit physical space, a base near the top plus a modest offset wraps, which checks the truncation in R1. An 8-bit offset lets the limit reach its 2**OFF_W maximum, which checks both ends of R10 and the limit-1 boundary of R3. Same-cycle write and lookup pairs on one entry check the old-contents rule for base and valid flag. A second reset mid-run checks that all entries are invalidated.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_INVALID = 2'b01,
    CAUSE_LIMIT   = 2'b10,
    CAUSE_PERM    = 2'b11
  } cause_e;

  // bit positions inside the three-bit permission mask
  localparam int PERM_X = 0;
  localparam int PERM_R = 1;
  localparam int PERM_W = 2;
  localparam int PERM_BITS = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 3,
  parameter int DAT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [DAT_W-1:0] wr_data,
  input  logic [SEG_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [DAT_W-1:0] rd_data
);
  localparam int DEPTH = 1 << SEG_W;

  // payload kept without reset so it maps onto distributed RAM
  logic [DAT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // valid flags need a reset, so each lives in its own flop
  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)
        vld[g] <= 1'b0;
      else if (wr_en && (wr_idx == SEG_W'(g)))
        vld[g] <= wr_valid;
    end
  end

  // asynchronous read: a write in this cycle lands at the edge, so reads see old data
  assign rd_data  = mem[rd_idx];
  assign rd_valid = vld[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic              ent_valid,
  input  logic [PA_W-1:0]   ent_base,
  input  logic [OFF_W:0]    ent_limit,
  input  logic [PERM_BITS-1:0] ent_perm,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        acc,
  output cause_e            cause,
  output logic [PA_W-1:0]   paddr
);
  logic [PA_W-1:0] off_ext;
  logic            in_bounds;
  logic            allowed;

  // offset widened (or trimmed) to the physical width
  if (PA_W > OFF_W) begin : g_pad
    assign off_ext = {{(PA_W-OFF_W){1'b0}}, off};
  end else begin : g_trim
    assign off_ext = off[PA_W-1:0];
  end

  assign in_bounds = ({1'b0, off} < ent_limit);

  always_comb begin
    unique case (acc_e'(acc))
      ACC_FETCH: allowed = ent_perm[PERM_X];
      ACC_LOAD:  allowed = ent_perm[PERM_R];
      ACC_STORE: allowed = ent_perm[PERM_W];
      default:   allowed = 1'b0;
    endcase
  end

  // priority: missing entry, then bound, then rights
  always_comb begin
    if (!ent_valid)      cause = CAUSE_INVALID;
    else if (!in_bounds) cause = CAUSE_LIMIT;
    else if (!allowed)   cause = CAUSE_PERM;
    else                 cause = CAUSE_NONE;
  end

  assign paddr = (cause == CAUSE_NONE) ? (ent_base + off_ext) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic             wr_valid,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W:0]   wr_limit,
  input  logic [2:0]       wr_perm
);
  localparam int LIM_W = OFF_W + 1;
  localparam int ENT_W = PA_W + LIM_W + PERM_BITS;

  logic [ENT_W-1:0]     ent_rd;
  logic                 ent_vld;
  logic [PA_W-1:0]      ent_base;
  logic [LIM_W-1:0]     ent_limit;
  logic [PERM_BITS-1:0] ent_perm;
  cause_e               cause_c;
  logic [PA_W-1:0]      paddr_c;

  seg_table #(
    .SEG_W (SEG_W),
    .DAT_W (ENT_W)
  ) table_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_seg),
    .wr_valid (wr_valid),
    .wr_data  ({wr_base, wr_limit, wr_perm}),
    .rd_idx   (req_seg),
    .rd_valid (ent_vld),
    .rd_data  (ent_rd)
  );

  assign {ent_base, ent_limit, ent_perm} = ent_rd;

  seg_check #(
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) check_i (
    .ent_valid (ent_vld),
    .ent_base  (ent_base),
    .ent_limit (ent_limit),
    .ent_perm  (ent_perm),
    .off       (req_off),
    .acc       (req_acc),
    .cause     (cause_c),
    .paddr     (paddr_c)
  );

  // single output stage; idle cycles leave every field at zero
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_paddr <= req_valid ? paddr_c : '0;
      rsp_fault <= req_valid && (cause_c != CAUSE_NONE);
      rsp_cause <= req_valid ? cause_c : CAUSE_NONE;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [1:0]      req_acc,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause
);
  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid));

  // R7
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault == (rsp_cause != 2'b00));

  // R7
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_paddr == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_fault && rsp_cause == 2'b00 && rsp_paddr == '0));

  // R4
  rsvd_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_acc) == 2'b11) |-> rsp_fault);

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_acc   (req_acc),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause)
);

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  localparam int SEG_W = 2;
  localparam int OFF_W = 8;
  localparam int PA_W  = 10;
  localparam int NSEG  = 1 << SEG_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             rsp_valid;
  logic [PA_W-1:0]  rsp_paddr;
  logic             rsp_fault;
  logic [1:0]       rsp_cause;
  logic             wr_en = 1'b0;
  logic [SEG_W-1:0] wr_seg = '0;
  logic             wr_valid = 1'b0;
  logic [PA_W-1:0]  wr_base = '0;
  logic [OFF_W:0]   wr_limit = '0;
  logic [2:0]       wr_perm = '0;

  always #2 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_valid(wr_valid), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_perm(wr_perm)
  );

  typedef struct {
    string          tag;
    bit             v;
    bit             f;
    bit [1:0]       c;
    bit [PA_W-1:0]  pa;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // shadow of the table, updated from the requirements only
  bit            m_vld [NSEG];
  int            m_base[NSEG];
  int            m_lim [NSEG];
  int            m_perm[NSEG];

  function automatic exp_t predict(string tag, bit rq, int seg, int off, int acc);
    exp_t e;
    bit ok_perm;
    e.tag = tag; e.v = rq; e.f = 0; e.c = 0; e.pa = '0;
    if (!rq) return e;
    ok_perm = (acc == 0) ? m_perm[seg][0] : (acc == 1) ? m_perm[seg][1] :
              (acc == 2) ? m_perm[seg][2] : 1'b0;
    if (!m_vld[seg])          e.c = 2'b01;
    else if (off >= m_lim[seg]) e.c = 2'b10;
    else if (!ok_perm)        e.c = 2'b11;
    e.f = (e.c != 0);
    if (!e.f) e.pa = PA_W'(m_base[seg] + off);
    return e;
  endfunction

  task automatic step(string tag, bit rq, int seg, int off, int acc,
                      bit wr, int widx, bit wv, int wb, int wl, int wp);
    @(negedge clk);
    q.push_back(predict(tag, rq, seg, off, acc));
    req_valid = rq; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
    wr_en = wr; wr_seg = SEG_W'(widx); wr_valid = wv;
    wr_base = PA_W'(wb); wr_limit = (OFF_W+1)'(wl); wr_perm = 3'(wp);
    if (wr) begin
      m_vld[widx] = wv; m_base[widx] = wb; m_lim[widx] = wl; m_perm[widx] = wp;
    end
  endtask

  task automatic req(string tag, int seg, int off, int acc);
    step(tag, 1, seg, off, acc, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wrt(int idx, bit wv, int wb, int wl, int wp);
    step("R9", 0, 0, 0, 0, 1, idx, wv, wb, wl, wp);
  endtask

  task automatic idle();
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NSEG; i++) m_vld[i] = 0;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_cause !== 2'b00 || rsp_paddr !== '0) begin
      errors++;
      $display("FAIL R9 reset state: got v=%b f=%b c=%b pa=%h, expected all zero",
               rsp_valid, rsp_fault, rsp_cause, rsp_paddr);
    end
    rst = 1'b0;
  endtask

  // monitor: compares one expected item per cycle after the output register
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rsp_valid !== e.v || rsp_fault !== e.f || rsp_cause !== e.c || rsp_paddr !== e.pa) begin
        errors++;
        $display("FAIL %s: got v=%b f=%b c=%b pa=%h, expected v=%b f=%b c=%b pa=%h",
                 e.tag, rsp_valid, rsp_fault, rsp_cause, rsp_paddr, e.v, e.f, e.c, e.pa);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      m_vld[i] = 0; m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0;
    end
    do_reset();
    // R5: nothing valid after reset
    req("R5", 0, 0, 1);
    req("R5", 3, 0, 0);
    // table: code, data, zero-limit, unused
    wrt(0, 1, 'h100, 'h40, 3'b011);
    wrt(1, 1, 'h200, 'h100, 3'b110);
    wrt(2, 1, 'h000, 0, 3'b111);
    wrt(3, 0, 'h000, 'h10, 3'b111);
    // R1 and R2: back-to-back hits
    req("R1", 0, 'h10, 0);
    req("R2", 0, 'h20, 1);
    req("R3", 0, 'h3F, 1);
    req("R3", 0, 'h40, 0);
    idle();
    req("R4", 0, 5, 2);
    req("R4", 1, 5, 0);
    req("R4", 1, 7, 3);
    req("R10", 1, 'hFF, 2);
    req("R10", 2, 0, 1);
    req("R5", 3, 2, 1);
    // R6: priority between simultaneous faults
    req("R6", 0, 'h40, 2);
    req("R6", 3, 'h50, 2);
    // R1: sum wraps in the physical space
    wrt(3, 1, 'h3F0, 'h100, 3'b111);
    req("R1", 3, 'h20, 1);
    // R8: same-cycle write and lookup see old contents
    step("R8", 1, 0, 4, 1, 1, 0, 1, 'h080, 'h40, 3'b011);
    req("R8", 0, 4, 1);
    step("R8", 1, 1, 9, 2, 1, 1, 0, 'h200, 'h100, 3'b110);
    req("R8", 1, 9, 2);
    idle();
    idle();
    // R5: a second reset invalidates the whole table
    do_reset();
    q.delete();
    req("R5", 0, 4, 1);
    req("R5", 3, 1, 0);
    idle();
    idle();
    @(negedge clk);
    finish_run();
  end

endmodule